// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four peripheral channels may use the system bus for a direct memory transfer, and it runs the handshake that takes the bus away from the processor. A channel takes part only when it is requesting and its enable bit is set. When any such channel is waiting, the arbiter raises a hold request. It waits for the processor's hold acknowledge, then grants exactly one channel through that channel's active-low acknowledge line.

The grant is fixed once it is issued. Changes on the request or enable lines have no effect on it until a one-cycle transfer-done pulse closes the transfer. The winner is picked either in fixed order, where channel 0 beats channel 3, or in rotating order, where the channel just served moves to the back of the queue. When nothing enabled is left to serve, the arbiter drops the hold request. It returns to idle once the processor takes the bus back.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, hold_o is 0 and ack_no is 4'b1111. Reset also returns the rotating order so that channel 0 is first.
- R2: A channel is eligible when req_i[c] and chan_en_i[c] are both 1. From idle, with hlda_i low, hold_o rises one clock after an eligible channel is sampled. Requests on channels whose enable bit is 0 never raise hold_o and never receive an acknowledge.
- R3: ack_no[c] low means channel c is granted. At most one bit of ack_no is low at any time, and only while hlda_i is 1. No bit goes low before hlda_i has been sampled high with hold_o asserted.
- R4: With rotate_i = 0, the eligible channel with the lowest index wins, and serving a channel does not change this order.
- R5: With rotate_i = 1, after channel g has been served, the search starts at channel (g+1) mod 4 and continues upward, wrapping around.
- R6: Once a channel is acknowledged, the grant stays on that channel while hlda_i is high, whatever happens on req_i and chan_en_i, until done_i is sampled high.
- R7: A done_i pulse releases the grant on the next clock. If eligible requests remain and hlda_i stays high, the next winner is acknowledged one clock after that, and hold_o stays asserted throughout.
- R8: If the arbiter holds the bus and no eligible request remains, hold_o drops one clock later. hold_o then stays low, even with new eligible requests, until hlda_i has been sampled low.
- R9: A done_i pulse that arrives while no channel is granted has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Service request per channel |
| chan_en_i | input | 4 | Per-channel enable mask |
| rotate_i | input | 1 | 1 selects rotating priority, 0 selects fixed |
| hlda_i | input | 1 | Processor has released the bus |
| done_i | input | 1 | One-cycle pulse that ends the current transfer |
| hold_o | output | 1 | Bus request to the processor |
| ack_no | output | 4 | Active-low channel acknowledge |

## Verification
hold_o responds one clock after an eligible request is sampled in idle. An acknowledge appears one clock after hlda_i is sampled high. After a done_i pulse, the grant drops on the first clock. The next acknowledge then follows on the second clock, or, if nothing is left to serve, hold_o falls on the second clock. The bench drives all inputs on the falling edge and reads the outputs on the falling edge after exactly that many rising edges, so every check lands in the cycle where its result is due. Between stimulus steps it also re-reads the outputs to confirm that the grant has not moved.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BUSREQ  = 2'd1,
    ST_XFER    = 2'd2,
    ST_RELEASE = 2'd3
  } arb_state_e;
endpackage

// File: rtl/dma_arb_pick.sv
// Picks the first eligible channel, searching upward from base_i with wrap.
module dma_arb_pick #(
  parameter int NUM_CH = 4,
  localparam int IW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] elig_i,
  input  logic [IW-1:0]     base_i,
  output logic [IW-1:0]     win_o,
  output logic              valid_o
);
  always_comb begin
    win_o   = '0;
    valid_o = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      logic [IW-1:0] idx;
      idx = base_i + IW'(i);
      if (!valid_o && elig_i[idx]) begin
        win_o   = idx;
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_ptr.sv
// Rotating priority base; reads as 0 in fixed mode.
module dma_arb_ptr #(
  parameter int NUM_CH = 4,
  localparam int IW = $clog2(NUM_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rotate_i,
  input  logic          finish_i,
  input  logic [IW-1:0] served_i,
  output logic [IW-1:0] base_o
);
  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ptr_q <= '0;
    else if (finish_i && rotate_i)  ptr_q <= served_i + IW'(1);
  end

  assign base_o = rotate_i ? ptr_q : '0;
endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       any_elig_i,
  input  logic       hlda_i,
  input  logic       done_i,
  output arb_state_e state_o,
  output logic       load_grant_o,
  output logic       finish_o
);
  arb_state_e state_q, state_d;

  assign load_grant_o = (state_q == ST_BUSREQ) && hlda_i && any_elig_i;
  assign finish_o     = (state_q == ST_XFER) && done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (any_elig_i && !hlda_i) state_d = ST_BUSREQ;
      ST_BUSREQ: begin
        if (!any_elig_i)       state_d = ST_RELEASE;
        else if (hlda_i)       state_d = ST_XFER;
      end
      ST_XFER:    if (done_i)  state_d = ST_BUSREQ;
      ST_RELEASE: if (!hlda_i) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IW = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] chan_en_i,
  input  logic              rotate_i,
  input  logic              hlda_i,
  input  logic              done_i,
  output logic              hold_o,
  output logic [NUM_CH-1:0] ack_no
);
  logic [NUM_CH-1:0] elig;
  logic [IW-1:0]     base, win, grant_q;
  logic              win_vld, load_grant, finish;
  arb_state_e        state;

  assign elig = req_i & chan_en_i;

  dma_arb_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .any_elig_i   (|elig),
    .hlda_i       (hlda_i),
    .done_i       (done_i),
    .state_o      (state),
    .load_grant_o (load_grant),
    .finish_o     (finish)
  );

  dma_arb_ptr #(.NUM_CH(NUM_CH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rotate_i (rotate_i),
    .finish_i (finish),
    .served_i (grant_q),
    .base_o   (base)
  );

  dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
    .elig_i  (elig),
    .base_i  (base),
    .win_o   (win),
    .valid_o (win_vld)
  );

  // Grant index frozen for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     grant_q <= '0;
    else if (load_grant && win_vld)  grant_q <= win;
  end

  assign hold_o = (state == ST_BUSREQ) || (state == ST_XFER);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ack
    assign ack_no[c] = !((state == ST_XFER) && hlda_i && (grant_q == IW'(c)));
  end
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] chan_en_i,
  input logic              hlda_i,
  input logic              done_i,
  input logic              hold_o,
  input logic [NUM_CH-1:0] ack_no
);
  // R3
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ack_no));
  // R3
  ack_needs_hlda_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_no != '1) |-> (hlda_i && hold_o));
  // R2
  hold_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(|(req_i & chan_en_i)));
  // R6
  grant_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_no != '1 && !done_i) |=> (!hlda_i || ack_no == $past(ack_no)));
  // R8
  release_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && hlda_i) |=> !hold_o);
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .chan_en_i (chan_en_i),
  .hlda_i    (hlda_i),
  .done_i    (done_i),
  .hold_o    (hold_o),
  .ack_no    (ack_no)
);

// File: tb/dma_req_arbiter_test.sv
`timescale 1ns/1ps
module dma_req_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0, en = '0;
  logic       rot = 1'b0, hlda = 1'b0, done = 1'b0;
  logic       hold;
  logic [3:0] ack_n;
  int n_chk = 0, n_fail = 0, ptr_m = 0;

  always #2 clk = ~clk;

  dma_req_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .chan_en_i(en),
    .rotate_i(rot), .hlda_i(hlda), .done_i(done), .hold_o(hold), .ack_no(ack_n)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [3:0] e, input int base);
    for (int i = 0; i < 4; i++) if (e[(base + i) % 4]) return (base + i) % 4;
    return -1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req = '0; en = '0; hlda = 1'b0; done = 1'b0;
    tick(); rst_n = 1'b1; ptr_m = 0; tick();
  endtask

  // One full transaction with checks at each due cycle
  task automatic serve(input logic [3:0] rq, input logic [3:0] mk, input logic r);
    int w;
    rot = r; req = rq; en = mk;
    w = pick(rq & mk, r ? ptr_m : 0);
    tick();
    if (w < 0) begin
      chk("R2 masked no hold", {hold, ack_n}, 5'b01111);
      req = '0; tick();
      return;
    end
    chk("R2 hold rise", {hold, ack_n}, 5'b11111);
    tick();
    chk("R3 no ack before hlda", {hold, ack_n}, 5'b11111);
    hlda = 1'b1; tick();
    chk(r ? "R5 rotate winner" : "R4 fixed winner", {hold, ack_n}, {1'b1, ~(4'b1 << w)});
    req = ~rq; en = ~mk; tick();
    chk("R6 grant held", {hold, ack_n}, {1'b1, ~(4'b1 << w)});
    req = '0; done = 1'b1; tick(); done = 1'b0;
    chk("R7 grant released", {hold, ack_n}, 5'b11111);
    if (r) ptr_m = (w + 1) % 4;
    tick();
    chk("R8 hold drops", {hold, ack_n}, 5'b01111);
    hlda = 1'b0; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset state", {hold, ack_n}, 5'b01111);

    // R4 and R2: every request/mask pair in fixed order
    for (int m = 0; m < 16; m++)
      for (int q = 0; q < 16; q++) serve(4'(q), 4'(m), 1'b0);

    // R5: prime the pointer from each channel, then every pattern
    for (int b = 0; b < 4; b++)
      for (int e = 1; e < 16; e++) begin
        serve(4'b1 << b, 4'hF, 1'b1);
        serve(4'(e), 4'hF, 1'b1);
      end

    // R9: done with no grant is ignored
    done = 1'b1; tick(); done = 1'b0;
    chk("R9 stray done", {hold, ack_n}, 5'b01111);
    serve(4'hF, 4'hF, 1'b1);

    // R1: reset restarts rotation at channel 0
    serve(4'b0100, 4'hF, 1'b1);
    do_reset();
    serve(4'hF, 4'hF, 1'b1);
    chk("R1 pointer restart", 5'(ptr_m), 5'd1);

    // R7: back-to-back grants under held hlda, fixed order
    rot = 1'b0; en = 4'hF; req = 4'b1010; tick();
    hlda = 1'b1; tick();
    chk("R7 first grant", {hold, ack_n}, 5'b11101);
    req = 4'b1000; done = 1'b1; tick(); done = 1'b0;
    chk("R7 gap cycle", {hold, ack_n}, 5'b11111);
    tick();
    chk("R7 next grant", {hold, ack_n}, 5'b10111);
    req = '0; done = 1'b1; tick(); done = 1'b0; tick();
    chk("R8 hold low", {hold, ack_n}, 5'b01111);
    // R8: new request while hlda still high must wait
    req = 4'b0001; tick();
    chk("R8 waits hlda low", {hold, ack_n}, 5'b01111);
    hlda = 1'b0; tick();
    chk("R8 idle again", {hold, ack_n}, 5'b01111);
    tick();
    chk("R8 hold after release", {hold, ack_n}, 5'b11111);
    req = '0; hlda = 1'b1; tick(); tick(); hlda = 1'b0; tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule